// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns the control state of a DC motor H-bridge into four registered gate enables: a high-side and a low-side switch for each of the two legs, A and B. Each control decision is formed by XOR-ing an external pin with a matching control-register bit. The decisions are the drive direction, the drive-versus-chop state and the decay style. A host can therefore invert any pin's meaning in software without rewiring the board.

While the bridge drives, one diagonal pair conducts. While the bridge is chopped (the off-time of a current-regulation cycle), the block either recirculates through both low-side switches or opens all four switches. This depends on the selected decay style and, in mixed style, on a phase input from the off-time timer.

Several conditions force switches off:
- Over-temperature, low regulator voltage, sleep or a missing wake-ready indication open every switch.
- A low high-side supply opens only the high-side switches.

A per-leg break-before-make sequencer enforces a programmable idle gap before any switch of a leg may close. This gap also keeps the two switches of one leg from conducting together.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: Direction is `dir_pin ^ dir_bit`. When driving, a value of 1 closes `gate_ah` and `gate_bl`. A value of 0 closes `gate_bh` and `gate_al`. A gate value of 1 means the switch conducts.
- R2: The bridge drives when `en_pin != en_bit`. When the two are equal, the bridge is in its chopped off-time.
- R3: Decay style is slow when `decay_pin != decay_bit` and mixed when they are equal. In mixed style, `fast_phase` = 1 selects fast decay and 0 selects slow decay.
- R4: In fast decay all four gates are open. In slow decay `gate_al` and `gate_bl` are closed and both high gates are open.
- R5: While `fault_vb` is 1, both high-side gates are open one cycle later. The low-side gates keep following their commands.
- R6: While `fault_temp` or `fault_vreg` is 1, all four gates are open one cycle later.
- R7: While `run_bit` is 0 (sleep) or `wake_ready` is 0, all four gates are open one cycle later.
- R8: The high and low gates of one leg are never 1 together.
- R9: A gate of a leg closes only after both gates of that leg have been open for at least `dead_time`+1 consecutive cycles. A leg that has stayed open since reset counts as long enough. A gate already closed stays closed while still commanded.
- R10: Gates are registered and follow the command of the previous cycle. In reset all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_pin | input | 1 | External direction pin |
| dir_bit | input | 1 | Direction register bit |
| en_pin | input | 1 | External drive/chop pin |
| en_bit | input | 1 | Drive/chop register bit |
| decay_pin | input | 1 | External decay-style pin |
| decay_bit | input | 1 | Decay-style register bit |
| fast_phase | input | 1 | Off-time timer phase, 1 = fast portion |
| wake_ready | input | 1 | Wake-up settle time has elapsed |
| run_bit | input | 1 | Register bit, 0 = sleep, 1 = normal |
| fault_temp | input | 1 | Over-temperature flag |
| fault_vreg | input | 1 | Low regulator voltage flag |
| fault_vb | input | 1 | Low high-side supply flag |
| dead_time | input | DT_W | Idle cycles required before a switch closes |
| gate_ah | output | 1 | Leg A high-side enable |
| gate_al | output | 1 | Leg A low-side enable |
| gate_bh | output | 1 | Leg B high-side enable |
| gate_bl | output | 1 | Leg B low-side enable |

## Verification
The bench builds the block with `DT_W` = 3, so the largest dead time of 7 equals the saturation value of each leg's idle counter. That corner is reached directly with a full reversal at `dead_time` = 7. Dead times of 0 and 3 exercise the shortest gap and a typical gap. A reversal, a drive-to-slow-decay change and a high-supply fault release each start a fresh idle gap on one or both legs. Random phases change the dead time while legs are mid-gap.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;

  localparam int NLEG = 2;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10
  } leg_cmd_e;

  typedef struct packed {
    logic fwd;
    logic drive_on;
    logic slow_sel;
  } bridge_mode_t;

  // Each decision is the XOR of a pin with its register bit.
  function automatic bridge_mode_t resolve_mode(
    input logic dir_pin, input logic dir_bit,
    input logic en_pin, input logic en_bit,
    input logic decay_pin, input logic decay_bit
  );
    bridge_mode_t m;
    m.fwd      = dir_pin ^ dir_bit;
    m.drive_on = en_pin ^ en_bit;
    m.slow_sel = decay_pin ^ decay_bit;
    return m;
  endfunction

  // Unmasked command for one leg (0 = A, 1 = B).
  function automatic leg_cmd_e leg_request(
    input bridge_mode_t m, input logic fast, input int unsigned leg
  );
    logic high_side;
    high_side = (leg == 0) ? m.fwd : !m.fwd;
    if (m.drive_on) return high_side ? LEG_HIGH : LEG_LOW;
    if (!m.slow_sel && fast) return LEG_OFF;
    return LEG_LOW;
  endfunction

endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import bridge_gate_pkg::*;
(
  input  bridge_mode_t    mode,
  input  logic            fast_phase,
  input  logic            kill_all,
  input  logic            kill_high,
  output logic [NLEG-1:0] req_h,
  output logic [NLEG-1:0] req_l
);

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_cmd_e cmd;
    assign cmd      = leg_request(mode, fast_phase, g);
    assign req_h[g] = !kill_all && !kill_high && (cmd == LEG_HIGH);
    assign req_l[g] = !kill_all && (cmd == LEG_LOW);
  end

endmodule

// File: rtl/bridge_leg_dt.sv
module bridge_leg_dt #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_time,
  input  logic            req_h,
  input  logic            req_l,
  output logic            q_h,
  output logic            q_l
);

  localparam logic [DT_W-1:0] IDLE_SAT = '1;

  logic [DT_W-1:0] idle_cnt;
  logic            leg_ready;
  logic            h_next;
  logic            l_next;

  assign leg_ready = !q_h && !q_l && (idle_cnt >= dead_time);
  assign h_next    = req_h && (q_h || leg_ready);
  assign l_next    = req_l && (q_l || leg_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_h      <= 1'b0;
      q_l      <= 1'b0;
      idle_cnt <= IDLE_SAT;
    end else begin
      q_h <= h_next;
      q_l <= l_next;
      if (q_h || q_l)             idle_cnt <= '0;
      else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_leg_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_h && q_l));

  assert_high_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_h) |-> !$past(q_l));

  assert_low_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_l) |-> !$past(q_h));

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_pin,
  input  logic            dir_bit,
  input  logic            en_pin,
  input  logic            en_bit,
  input  logic            decay_pin,
  input  logic            decay_bit,
  input  logic            fast_phase,
  input  logic            wake_ready,
  input  logic            run_bit,
  input  logic            fault_temp,
  input  logic            fault_vreg,
  input  logic            fault_vb,
  input  logic [DT_W-1:0] dead_time,
  output logic            gate_ah,
  output logic            gate_al,
  output logic            gate_bh,
  output logic            gate_bl
);

  bridge_mode_t    mode_w;
  logic            kill_all;
  logic            kill_high;
  logic [NLEG-1:0] req_h;
  logic [NLEG-1:0] req_l;
  logic [NLEG-1:0] q_h;
  logic [NLEG-1:0] q_l;

  assign mode_w    = resolve_mode(dir_pin, dir_bit, en_pin, en_bit, decay_pin, decay_bit);
  assign kill_all  = fault_temp || fault_vreg || !run_bit || !wake_ready;
  assign kill_high = fault_vb;

  bridge_cmd_decode u_decode (
    .mode       (mode_w),
    .fast_phase (fast_phase),
    .kill_all   (kill_all),
    .kill_high  (kill_high),
    .req_h      (req_h),
    .req_l      (req_l)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    bridge_leg_dt #(.DT_W(DT_W)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .dead_time (dead_time),
      .req_h     (req_h[g]),
      .req_l     (req_l[g]),
      .q_h       (q_h[g]),
      .q_l       (q_l[g])
    );
  end

  assign gate_ah = q_h[0];
  assign gate_al = q_l[0];
  assign gate_bh = q_h[1];
  assign gate_bl = q_l[1];

  assert_vb_highs_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kill_high |=> (!gate_ah && !gate_bh));

  assert_fault_all_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_temp || fault_vreg) |=> ({gate_ah, gate_al, gate_bh, gate_bl} == 4'b0000));

  assert_sleep_all_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_bit || !wake_ready) |=> ({gate_ah, gate_al, gate_bh, gate_bl} == 4'b0000));

  assert_one_diagonal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !((gate_ah && gate_bh) || (gate_ah && gate_al) || (gate_bh && gate_bl)));

endmodule

// File: tb/bridge_gate_ctrl_tb_top.sv
module bridge_gate_ctrl_tb_top;

  localparam int DT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_pin = 0, dir_bit = 0, en_pin = 0, en_bit = 0;
  logic decay_pin = 0, decay_bit = 0, fast_phase = 0;
  logic wake_ready = 0, run_bit = 0;
  logic fault_temp = 0, fault_vreg = 0, fault_vb = 0;
  logic [DT_W-1:0] dead_time = '0;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bridge_gate_ctrl #(.DT_W(DT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dir_pin(dir_pin), .dir_bit(dir_bit),
    .en_pin(en_pin), .en_bit(en_bit),
    .decay_pin(decay_pin), .decay_bit(decay_bit),
    .fast_phase(fast_phase), .wake_ready(wake_ready), .run_bit(run_bit),
    .fault_temp(fault_temp), .fault_vreg(fault_vreg), .fault_vb(fault_vb),
    .dead_time(dead_time),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
  );

  // Wanted gate pattern {ah, al, bh, bl}, before break-before-make.
  function automatic logic [3:0] wanted();
    logic [3:0] w;
    if (fault_temp || fault_vreg || !run_bit || !wake_ready) return 4'b0000;
    if (en_pin != en_bit)
      w = ((dir_pin != dir_bit) ? 4'b1001 : 4'b0110);
    else if ((decay_pin != decay_bit) || !fast_phase)
      w = 4'b0101;
    else
      w = 4'b0000;
    if (fault_vb) begin
      w[3] = 1'b0;
      w[1] = 1'b0;
    end
    return w;
  endfunction

  // Reference model: per leg, count how long it has been fully open.
  logic eh [2];
  logic el [2];
  int   quiet [2];
  always @(posedge clk or negedge rst_n) begin
    logic [3:0] w;
    logic rh, rl, gap_ok;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        eh[k] <= 1'b0; el[k] <= 1'b0; quiet[k] <= 1000;
      end
    end else begin
      w = wanted();
      for (int k = 0; k < 2; k++) begin
        rh = (k == 0) ? w[3] : w[1];
        rl = (k == 0) ? w[2] : w[0];
        gap_ok = !eh[k] && !el[k] && (quiet[k] >= int'(dead_time));
        eh[k]    <= rh && (eh[k] || gap_ok);
        el[k]    <= rl && (el[k] || gap_ok);
        quiet[k] <= (eh[k] || el[k]) ? 0 : quiet[k] + 1;
      end
    end
  end

  function automatic logic [3:0] gates();
    return {gate_ah, gate_al, gate_bh, gate_bl};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_checks++;
    if (gates() !== exp) begin
      n_fail++;
      $display("FAIL %s: gates ah,al,bh,bl actual %b expected %b at %0t", tag, gates(), exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string model_tag();
    if (fault_temp || fault_vreg) return "R6";
    if (!run_bit || !wake_ready) return "R7";
    if (fault_vb) return "R5";
    return "R9";
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0000_5eed);
    tick(3);
    check("R10 reset", 4'b0000);
    rst_n = 1'b1;

    // R7: drive requested but wake not ready
    dead_time = 3'd3; run_bit = 1; dir_pin = 1; en_pin = 1;
    tick(2);
    check("R7 wake low", 4'b0000);

    // R1/R2: forward drive, legs idle since reset
    wake_ready = 1;
    tick(1);
    check("R1 forward", 4'b1001);

    // R9/R1: reversal with dead_time 3 -> 4 open cycles
    dir_bit = 1;
    tick(4);
    check("R9 reversal gap", 4'b0000);
    tick(1);
    check("R1 reverse", 4'b0110);

    // R3/R4: chop with slow style; leg A keeps low, leg B waits
    en_bit = 1; decay_pin = 1;
    tick(1);
    check("R4 slow A keeps low", 4'b0100);
    tick(3);
    check("R9 leg B gap", 4'b0100);
    tick(1);
    check("R4 slow decay", 4'b0101);

    // R3/R4: mixed style, fast phase then slow phase
    decay_bit = 1; fast_phase = 1;
    tick(1);
    check("R4 fast decay", 4'b0000);
    fast_phase = 0;
    tick(6);
    check("R3 mixed slow phase", 4'b0101);

    // R5: forward drive with high supply low
    en_bit = 0; dir_bit = 0; fault_vb = 1;
    tick(1);
    check("R5 highs open", 4'b0001);
    tick(4);
    check("R5 highs stay open", 4'b0001);
    fault_vb = 0;
    tick(5);
    check("R5 release", 4'b1001);

    // R6: thermal and regulator faults
    fault_temp = 1;
    tick(1);
    check("R6 temp", 4'b0000);
    fault_temp = 0;
    tick(5);
    check("R6 temp cleared", 4'b1001);
    fault_vreg = 1;
    tick(1);
    check("R6 vreg", 4'b0000);
    fault_vreg = 0;
    tick(5);

    // R7: sleep
    run_bit = 0;
    tick(1);
    check("R7 sleep", 4'b0000);
    run_bit = 1;
    tick(5);
    check("R10 wake drive", 4'b1001);

    // R9: dead time 0 reversal, single open cycle
    dead_time = 3'd0; dir_bit = 1;
    tick(1);
    check("R9 zero dt open", 4'b0000);
    tick(1);
    check("R9 zero dt close", 4'b0110);

    // R9: maximum dead time 7 equals idle saturation
    dead_time = 3'd7; dir_bit = 0;
    tick(8);
    check("R9 max dt open", 4'b0000);
    tick(1);
    check("R9 max dt close", 4'b1001);

    // Random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      dir_pin    = $urandom_range(0, 7) == 0 ? ~dir_pin : dir_pin;
      dir_bit    = $urandom_range(0, 15) == 0 ? ~dir_bit : dir_bit;
      en_pin     = $urandom_range(0, 3) == 0 ? ~en_pin : en_pin;
      en_bit     = $urandom_range(0, 15) == 0 ? ~en_bit : en_bit;
      decay_pin  = $urandom_range(0, 15) == 0 ? ~decay_pin : decay_pin;
      decay_bit  = $urandom_range(0, 15) == 0 ? ~decay_bit : decay_bit;
      fast_phase = $urandom_range(0, 3) == 0 ? ~fast_phase : fast_phase;
      fault_temp = $urandom_range(0, 63) == 0;
      fault_vreg = $urandom_range(0, 63) == 0;
      fault_vb   = $urandom_range(0, 31) == 0;
      run_bit    = $urandom_range(0, 63) != 0;
      wake_ready = $urandom_range(0, 63) != 0;
      if ($urandom_range(0, 31) == 0) dead_time = DT_W'($urandom_range(0, 7));
      tick(1);
      check({model_tag(), " model"}, {eh[0], el[0], eh[1], el[1]});
      if (gate_ah && gate_al || gate_bh && gate_bl) begin
        n_checks++; n_fail++;
        $display("FAIL R8: leg shoot-through actual %b expected no leg 11", gates());
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule